// File: doc/BRIEF.md
# FFT Output Centering Reorder Buffer

This block sits behind an FFT core and turns each output frame into centered order, so that the zero-frequency bin lands in the middle of the frame instead of at position 0. It accepts one sample per cycle while `in_valid` is high. It writes every sample into an on-chip two-bank RAM. It then reads the frame back in an order that puts the upper half of the spectrum first and the lower half second. All addressing comes from counters and comparators, with no lookup table.

A build-time option selects the order in which the FFT delivers its samples. In natural order, arrival j carries bin j. In bit-reversed order, arrival j carries bin bitrev(j). In bit-reversed mode the block maps the samples straight into centered order, so no separate natural-order reorder stage is needed upstream. A read is issued as soon as the sample it needs is in the RAM. In natural mode the output therefore starts after half a frame, and in bit-reversed mode it starts after two samples.

Top module: `cshift_top`

## Requirements
- R1: After reset, `out_valid` and `out_sof` are low, and they stay low until frame data has been written.
- R2: Samples with `in_valid` high that arrive before the first sample carrying `in_sof` are discarded and never reach the output. The sample that carries the first `in_sof` is arrival 0 of the first frame.
- R3: After that first `in_sof`, every NPTS consecutive accepted samples form one frame. An `in_sof` on any later sample has no effect on framing or on output order.
- R4: With IN_ORDER = ORD_NATURAL (arrival j carries bin j), output position k of a frame (k = 0..NPTS-1) carries bin k XOR NPTS/2. The output is bins NPTS/2..NPTS-1 followed by bins 0..NPTS/2-1.
- R5: With IN_ORDER = ORD_BITREV (arrival j carries bin bitrev(j), with the bits of j reversed over log2(NPTS) bits), output position k carries bin k XOR NPTS/2, the same centered order as R4.
- R6: `out_sof` is high only together with `out_valid` on position 0 of each frame. Each frame produces exactly NPTS cycles with `out_valid` high.
- R7: In natural mode with continuous input, the first output of a frame appears NPTS/2+2 cycles after the cycle in which that frame's first sample is presented. Back-to-back input frames give a gap-free output stream.
- R8: Cycles with `in_valid` low pause the write side. The output never presents a sample before that sample has been written, and the order of R4/R5 is kept.
- R9: Back-to-back frames never overwrite samples that have not yet been read. One frame is written into one bank while the previous frame is read from the other.
- R10: In bit-reversed mode with continuous input, the first output of a frame appears 3 cycles after the cycle in which that frame's first sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present this cycle |
| in_sof | input | 1 | Input sample is the first of a frame (used for first alignment) |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | Output sample is present this cycle |
| out_sof | output | 1 | Output sample is position 0 of a frame |
| out_data | output | DW | Output sample in centered order |

## Verification
The assertions run on every cycle and cover four properties. A write never lands in a bank whose previous frame is still unread. The output never runs ahead of the number of samples written. `out_sof` appears only on every NPTS-th valid output. `out_sof` never appears without `out_valid`. The actual permutation of the data, the start latency in each input order, the gap-free stream for back-to-back frames, and the discarding of samples before alignment can only be shown by the bench scenarios. Those scenarios feed identical frames to a natural-order and a bit-reversed instance and compare every output against the centered index.

// File: rtl/cshift_pkg.sv
package cshift_pkg;

   // Order in which the upstream transform delivers the bins of a frame
   typedef enum logic {
      ORD_NATURAL = 1'b0,
      ORD_BITREV  = 1'b1
   } order_e;

endpackage

// File: rtl/cshift_ram.sv
// Simple dual-port RAM: one write port, one registered read port.
module cshift_ram #(
   parameter int DW    = 16,
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_q
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
      if (rd_en) begin
         rd_q <= mem[rd_addr];
      end
   end

endmodule

// File: rtl/cshift_wr_ctrl.sv
// Write-side sequencer: aligns on the first start flag, counts arrivals,
// alternates banks per frame and tracks which banks hold a complete frame.
module cshift_wr_ctrl #(
   parameter int NPTS = 64,
   localparam int AW  = $clog2(NPTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic          rel_en,
   input  logic          rel_bank,
   output logic          wr_en,
   output logic [AW:0]   wr_addr,
   output logic          wbank,
   output logic [AW-1:0] wcnt,
   output logic [1:0]    bank_full
);

   localparam logic [AW-1:0] LAST = AW'(NPTS - 1);

   logic aligned;
   logic accept;
   logic frame_end;

   assign accept    = in_valid && (aligned || in_sof);
   assign frame_end = accept && (wcnt == LAST);
   assign wr_en     = accept;
   assign wr_addr   = {wbank, wcnt};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aligned   <= 1'b0;
         wbank     <= 1'b0;
         wcnt      <= '0;
         bank_full <= 2'b00;
      end else begin
         if (in_valid && in_sof) begin
            aligned <= 1'b1;
         end
         if (accept) begin
            wcnt <= frame_end ? '0 : wcnt + 1'b1;
            if (frame_end) begin
               wbank <= ~wbank;
            end
         end
         if (rel_en) begin
            bank_full[rel_bank] <= 1'b0;
         end
         if (frame_end) begin
            bank_full[wbank] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cshift_rd_ctrl.sv
// Read-side address generator. Walks output positions 0..NPTS-1 and maps
// each to the RAM offset that holds bin (pos XOR NPTS/2). It issues a read
// only once that offset has been written.
module cshift_rd_ctrl #(
   parameter int                 NPTS     = 64,
   parameter cshift_pkg::order_e IN_ORDER = cshift_pkg::ORD_NATURAL,
   localparam int                AW       = $clog2(NPTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wbank,
   input  logic [AW-1:0] wcnt,
   input  logic [1:0]    bank_full,
   output logic          rd_en,
   output logic [AW:0]   rd_addr,
   output logic          rd_first,
   output logic          rel_en,
   output logic          rel_bank
);

   localparam logic [AW-1:0] LAST = AW'(NPTS - 1);
   localparam logic [AW-1:0] HALF = AW'(NPTS / 2);

   logic          rbank;
   logic [AW-1:0] rpos;
   logic [AW-1:0] map_off;
   logic          partial_ok;

   generate
      if (IN_ORDER == cshift_pkg::ORD_NATURAL) begin : g_nat
         // bin k XOR N/2 is stored at offset k XOR N/2: flip the MSB
         assign map_off = rpos ^ HALF;
      end else begin : g_rev
         // bin n is stored at offset bitrev(n); bitrev(k XOR N/2) flips the LSB
         logic [AW-1:0] rpos_rev;
         for (genvar gi = 0; gi < AW; gi++) begin : g_bit
            assign rpos_rev[gi] = rpos[AW-1-gi];
         end
         assign map_off = rpos_rev ^ AW'(1);
      end
   endgenerate

   assign partial_ok = (wbank == rbank) && (wcnt > map_off);
   assign rd_en      = bank_full[rbank] || partial_ok;
   assign rd_addr    = {rbank, map_off};
   assign rd_first   = rd_en && (rpos == '0);
   assign rel_en     = rd_en && (rpos == LAST);
   assign rel_bank   = rbank;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbank <= 1'b0;
         rpos  <= '0;
      end else if (rd_en) begin
         rpos <= (rpos == LAST) ? '0 : rpos + 1'b1;
         if (rpos == LAST) begin
            rbank <= ~rbank;
         end
      end
   end

endmodule

// File: rtl/cshift_top.sv
// Centering reorder buffer for FFT output frames.
module cshift_top #(
   parameter int                 NPTS     = 64,
   parameter int                 DW       = 16,
   parameter cshift_pkg::order_e IN_ORDER = cshift_pkg::ORD_NATURAL,
   localparam int                AW       = $clog2(NPTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic          out_sof,
   output logic [DW-1:0] out_data
);

   generate
      if (NPTS < 8 || NPTS > 4096 || (NPTS & (NPTS - 1)) != 0) begin : g_bad_npts
         $error("cshift_top: NPTS must be a power of two in 8..4096");
      end
      if (DW < 1) begin : g_bad_dw
         $error("cshift_top: DW must be at least 1");
      end
   endgenerate

   logic          wr_en;
   logic [AW:0]   wr_addr;
   logic          wbank;
   logic [AW-1:0] wcnt;
   logic [1:0]    bank_full;
   logic          rd_en;
   logic [AW:0]   rd_addr;
   logic          rd_first;
   logic          rel_en;
   logic          rel_bank;

   cshift_wr_ctrl #(.NPTS(NPTS)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .rel_en    (rel_en),
      .rel_bank  (rel_bank),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wbank     (wbank),
      .wcnt      (wcnt),
      .bank_full (bank_full)
   );

   cshift_rd_ctrl #(.NPTS(NPTS), .IN_ORDER(IN_ORDER)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wbank     (wbank),
      .wcnt      (wcnt),
      .bank_full (bank_full),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_first  (rd_first),
      .rel_en    (rel_en),
      .rel_bank  (rel_bank)
   );

   cshift_ram #(.DW(DW), .DEPTH(2 * NPTS)) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (in_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_q    (out_data)
   );

   // Flags follow the RAM's one-cycle read latency
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         out_valid <= rd_en;
         out_sof   <= rd_first;
      end
   end

endmodule

// File: rtl/cshift_chk.sv
module cshift_chk #(
   parameter int NPTS = 64,
   localparam int AW  = $clog2(NPTS)
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [AW:0] wr_addr,
   input logic [1:0]  bank_full,
   input logic        out_valid,
   input logic        out_sof
);

   logic [31:0]   wr_total;
   logic [31:0]   out_total;
   logic [AW-1:0] out_pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_total  <= '0;
         out_total <= '0;
         out_pos   <= '0;
      end else begin
         if (wr_en) wr_total <= wr_total + 1;
         if (out_valid) begin
            out_total <= out_total + 1;
            out_pos   <= out_pos + 1'b1;
         end
      end
   end

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !bank_full[wr_addr[AW]]); // R9

   AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_total < wr_total)); // R8

   AST_SOF_ON_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sof == (out_pos == '0))); // R6

   AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid); // R6

endmodule

bind cshift_top cshift_chk #(.NPTS(NPTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .bank_full (bank_full),
   .out_valid (out_valid),
   .out_sof   (out_sof)
);

// File: tb/tb_cshift_top.sv
module tb_cshift_top;

   localparam int N    = 64;
   localparam int HALF = N / 2;
   localparam int DW   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk; // 50 MHz

   logic          n_valid = 1'b0, n_sof = 1'b0;
   logic [DW-1:0] n_data = '0;
   logic          b_valid = 1'b0, b_sof = 1'b0;
   logic [DW-1:0] b_data = '0;
   logic          on_valid, on_sof, ob_valid, ob_sof;
   logic [DW-1:0] on_data, ob_data;

   cshift_top #(.NPTS(N), .DW(DW), .IN_ORDER(cshift_pkg::ORD_NATURAL)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .in_sof(n_sof), .in_data(n_data),
      .out_valid(on_valid), .out_sof(on_sof), .out_data(on_data));

   cshift_top #(.NPTS(N), .DW(DW), .IN_ORDER(cshift_pkg::ORD_BITREV)) dut_br (
      .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_sof(b_sof), .in_data(b_data),
      .out_valid(ob_valid), .out_sof(ob_sof), .out_data(ob_data));

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int fsent = 0;
   int start_cyc = 0;
   int nf = 0, nk = 0, n_tot = 0, first_n = 0, last_n = 0;
   int bf = 0, bk = 0, b_tot = 0, first_b = 0;
   bit arm_n = 0, arm_b = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [5:0] brev(input logic [5:0] v);
      logic [5:0] r;
      for (int i = 0; i < 6; i++) r[i] = v[5-i];
      return r;
   endfunction

   function automatic logic [DW-1:0] val(input int f, input int n);
      return DW'(((f & 255) << 8) | n);
   endfunction

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, got, exp, cyc);
      end
   endtask

   // Output monitors, sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n && on_valid) begin
         chk(on_data == val(nf, nk ^ HALF), "R4 natural centered order", on_data, val(nf, nk ^ HALF));
         chk(on_sof == (nk == 0), "R6 natural sof position", on_sof, nk == 0);
         if (nk == 0 && arm_n) begin first_n = cyc; arm_n = 0; end
         last_n = cyc;
         n_tot++;
         nk++;
         if (nk == N) begin nk = 0; nf++; end
      end
      if (rst_n && ob_valid) begin
         chk(ob_data == val(bf, bk ^ HALF), "R5 bitrev centered order", ob_data, val(bf, bk ^ HALF));
         chk(ob_sof == (bk == 0), "R6 bitrev sof position", ob_sof, bk == 0);
         if (bk == 0 && arm_b) begin first_b = cyc; arm_b = 0; end
         b_tot++;
         bk++;
         if (bk == N) begin bk = 0; bf++; end
      end
   end

   task automatic idle(input int n);
      @(negedge clk);
      n_valid = 0; n_sof = 0; b_valid = 0; b_sof = 0;
      repeat (n) @(negedge clk);
   endtask

   // Drive one frame to both instances; gaps inserts idle cycles, sof_mid
   // raises the start flag again on arrival 5
   task automatic send_frame(input bit gaps, input bit sof_mid);
      for (int j = 0; j < N; j++) begin
         if (gaps && (j % 5 == 3)) begin
            @(negedge clk);
            n_valid = 0; b_valid = 0; n_sof = 0; b_sof = 0;
            @(negedge clk);
         end
         @(negedge clk);
         if (j == 0) start_cyc = cyc;
         n_valid = 1; b_valid = 1;
         n_sof = (j == 0) || (sof_mid && j == 5);
         b_sof = n_sof;
         n_data = val(fsent, j);
         b_data = val(fsent, int'(brev(6'(j))));
      end
      fsent++;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (5) @(negedge clk);
      chk(on_valid == 0 && on_sof == 0, "R1 natural outputs idle in reset", on_valid, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk(on_valid == 0 && on_sof == 0, "R1 natural outputs idle after reset", on_valid, 0);
      chk(ob_valid == 0 && ob_sof == 0, "R1 bitrev outputs idle after reset", ob_valid, 0);
   endtask

   task automatic t_presync();
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         n_valid = 1; b_valid = 1; n_sof = 0; b_sof = 0;
         n_data = '1; b_data = '1;
      end
      idle(3 * N);
      chk(n_tot == 0, "R2 natural drops unaligned samples", n_tot, 0);
      chk(b_tot == 0, "R2 bitrev drops unaligned samples", b_tot, 0);
   endtask

   task automatic t_latency();
      arm_n = 1; arm_b = 1;
      send_frame(0, 0);
      idle(2 * N);
      chk(first_n - start_cyc == HALF + 2, "R7 natural start latency", first_n - start_cyc, HALF + 2);
      chk(first_b - start_cyc == 3, "R10 bitrev start latency", first_b - start_cyc, 3);
      chk(n_tot == N && b_tot == N, "R6 one frame gives N outputs", n_tot, N);
   endtask

   task automatic t_back_to_back();
      int n0 = n_tot, b0 = b_tot, s0;
      arm_n = 1;
      send_frame(0, 0);
      s0 = start_cyc;
      for (int f = 1; f < 4; f++) send_frame(0, 0);
      idle(3 * N);
      chk(first_n - s0 == HALF + 2, "R7 natural latency back-to-back", first_n - s0, HALF + 2);
      chk(last_n - first_n == 4 * N - 1, "R7 gap-free natural stream", last_n - first_n, 4 * N - 1);
      chk(n_tot - n0 == 4 * N, "R9 all back-to-back natural samples out", n_tot - n0, 4 * N);
      chk(b_tot - b0 == 4 * N, "R9 all back-to-back bitrev samples out", b_tot - b0, 4 * N);
   endtask

   task automatic t_stall();
      int n0 = n_tot, b0 = b_tot;
      send_frame(1, 0);
      send_frame(1, 0);
      idle(3 * N);
      chk(n_tot - n0 == 2 * N, "R8 stalled natural frames complete", n_tot - n0, 2 * N);
      chk(b_tot - b0 == 2 * N, "R8 stalled bitrev frames complete", b_tot - b0, 2 * N);
   endtask

   task automatic t_sof_mid();
      int n0 = n_tot, b0 = b_tot;
      send_frame(0, 1);
      send_frame(0, 0);
      idle(3 * N);
      chk(n_tot - n0 == 2 * N, "R3 mid-frame sof ignored natural", n_tot - n0, 2 * N);
      chk(b_tot - b0 == 2 * N, "R3 mid-frame sof ignored bitrev", b_tot - b0, 2 * N);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      t_reset();
      t_presync();
      t_latency();
      t_back_to_back();
      t_stall();
      t_sof_mid();
      chk(n_tot == fsent * N, "R6 natural total outputs", n_tot, fsent * N);
      chk(b_tot == fsent * N, "R5 bitrev total outputs", b_tot, fsent * N);
      report();
      $finish;
   end

endmodule